// File: doc/BRIEF.md
# Root-Tagged Translation Cache with Invalidation

This block is a small fully associative cache that maps guest page numbers to host page numbers. Every entry records the frame of the page-table root pointer under which it was created, so translations from different guest contexts can sit in the cache side by side. A lookup presents the current root frame and a guest page number. It receives a combinational hit and the host page number in the same cycle.

Entries are written through a fill port. They are removed by an invalidate command made of a type code and a 128-bit descriptor. Type 1 removes the entries that belong to one root frame, taken from descriptor bits 51:12. Type 2 empties the whole cache. Any other type removes nothing and reports an error. Each command finishes in one cycle and is acknowledged with a one-cycle done pulse. A fill that arrives together with an invalidation that would cover it is discarded, so a stale translation cannot survive the command.

Top module: `ctx_xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and inv_done and inv_err are low.
- R2: lk_hit is high in the same cycle when a valid entry holds both lk_root and lk_gpn. lk_hpn then carries the host page of the lowest-numbered such entry. On a miss lk_hpn is zero.
- R3: A performed fill writes the lowest-numbered invalid entry. When every entry is valid, it writes the entry chosen by a victim pointer instead. The victim pointer is zero after reset and advances by one, wrapping to zero after the last entry, on each such replacement.
- R4: An invalidation with inv_type equal to 1 clears exactly the valid entries whose stored root frame equals inv_desc[51:12], and leaves all other entries untouched. Descriptor bits 127:64, 63:52 and 11:0 have no effect.
- R5: An invalidation with inv_type equal to 2 clears every entry, whatever root frame it holds.
- R6: inv_done is high for exactly the one cycle after each cycle in which inv_req is high, whatever the type. It is low at all other times.
- R7: An invalidation with any inv_type other than 1 or 2 clears no entry and raises inv_err together with inv_done. Types 1 and 2 leave inv_err low.
- R8: A fill in the same cycle as a type-1 request whose descriptor frame equals fill_root, or as a type-2 request, is discarded; any other fill in a request cycle is performed. A lookup in a request cycle still sees the contents as they were before that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_root | input | 40 | Root-pointer frame of the current context |
| lk_gpn | input | GPN_W | Guest page number to translate |
| lk_hit | output | 1 | A valid entry matches root frame and guest page |
| lk_hpn | output | HPN_W | Host page number of the hit, zero on a miss |
| fill_en | input | 1 | Write a new translation this cycle |
| fill_root | input | 40 | Root frame tag of the new translation |
| fill_gpn | input | GPN_W | Guest page number of the new translation |
| fill_hpn | input | HPN_W | Host page number of the new translation |
| inv_req | input | 1 | Invalidate command this cycle |
| inv_type | input | TYPE_W | 1 = single root frame, 2 = all entries |
| inv_desc | input | 128 | Descriptor; bits 51:12 give the root frame |
| inv_done | output | 1 | One-cycle acknowledge after a command |
| inv_err | output | 1 | The acknowledged command had an unsupported type |

## Verification
A valid bit left set by mistake shows up as a stale hit on the first lookup of that root frame and page after the command. A valid bit cleared by mistake shows up as a miss on a key that should still hit. Either one appears the cycle after the faulty edge, because lookups are combinational. A victim pointer that has drifted stays hidden while free entries remain. It shows only when a replacement in a full cache evicts the wrong translation, which the next lookup of the evicted or surviving key then exposes. For that reason the random stimulus keeps a small pool of keys, so the cache fills and overflows often.

// File: rtl/ctx_xlate_cache.sv
`timescale 1ns/1ps
module ctx_xlate_cache #(
  parameter int ENTRIES = 16,
  parameter int GPN_W   = 20,
  parameter int HPN_W   = 24,
  parameter int TYPE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [39:0]       lk_root,
  input  logic [GPN_W-1:0]  lk_gpn,
  output logic              lk_hit,
  output logic [HPN_W-1:0]  lk_hpn,
  input  logic              fill_en,
  input  logic [39:0]       fill_root,
  input  logic [GPN_W-1:0]  fill_gpn,
  input  logic [HPN_W-1:0]  fill_hpn,
  input  logic              inv_req,
  input  logic [TYPE_W-1:0] inv_type,
  input  logic [127:0]      inv_desc,
  output logic              inv_done,
  output logic              inv_err
);
  localparam int TAG_LO = 12;
  localparam int TAG_HI = 51;
  localparam int TAG_W  = TAG_HI - TAG_LO + 1;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [GPN_W-1:0]   gpn_q [ENTRIES];
  logic [HPN_W-1:0]   hpn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] kill;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic [TAG_W-1:0]   inv_tag;

  assign inv_tag = inv_desc[TAG_HI:TAG_LO];
  wire unused_desc = ^{inv_desc[127:TAG_HI+1], inv_desc[TAG_LO-1:0]};

  wire inv_single = inv_req && (inv_type == TYPE_W'(1));
  wire inv_global = inv_req && (inv_type == TYPE_W'(2));
  wire inv_bad    = inv_req && !inv_single && !inv_global;
  wire all_full   = &vld;
  wire fill_drop  = inv_global || (inv_single && (fill_root == inv_tag));
  wire fill_go    = fill_en && !fill_drop;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign lk_match[i] = vld[i] && (tag_q[i] == lk_root) && (gpn_q[i] == lk_gpn);
    assign kill[i]     = inv_global || (inv_single && (tag_q[i] == inv_tag));
  end

  assign lk_hit = |lk_match;

  always_comb begin
    lk_hpn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_match[i]) lk_hpn = hpn_q[i];
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  assign fill_idx = all_full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      rr_q     <= '0;
      inv_done <= 1'b0;
      inv_err  <= 1'b0;
    end else begin
      inv_done <= inv_req;
      inv_err  <= inv_bad;
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_go && fill_idx == IDX_W'(i)) vld[i] <= 1'b1;
        else if (kill[i]) vld[i] <= 1'b0;
      end
      if (fill_go && all_full)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_go && fill_idx == IDX_W'(i)) begin
        tag_q[i] <= fill_root;
        gpn_q[i] <= fill_gpn;
        hpn_q[i] <= fill_hpn;
      end
    end
  end

  // R6
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |=> inv_done);
  // R6
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_req |=> !inv_done);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_err |-> inv_done);
  // R7
  bad_type_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_bad && !fill_en) |=> $stable(vld));
  // R5
  global_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_global && !fill_en) |=> (vld == '0));
  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (|vld));
  // R3
  fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_req && !all_full) |=> ($countones(vld) == $past($countones(vld)) + 1));
  // R3
  full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_full && !inv_req) |=> all_full);
endmodule

// File: tb/ctx_xlate_cache_tb_top.sv
`timescale 1ns/1ps
module ctx_xlate_cache_tb_top;
  localparam int N = 16, GW = 20, HW = 24, TW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [39:0] lk_root, fill_root;
  logic [GW-1:0] lk_gpn, fill_gpn;
  logic [HW-1:0] lk_hpn, fill_hpn;
  logic lk_hit, fill_en, inv_req, inv_done, inv_err;
  logic [TW-1:0] inv_type;
  logic [127:0] inv_desc;

  ctx_xlate_cache #(.ENTRIES(N), .GPN_W(GW), .HPN_W(HW), .TYPE_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_root(lk_root), .lk_gpn(lk_gpn), .lk_hit(lk_hit),
    .lk_hpn(lk_hpn), .fill_en(fill_en), .fill_root(fill_root), .fill_gpn(fill_gpn),
    .fill_hpn(fill_hpn), .inv_req(inv_req), .inv_type(inv_type), .inv_desc(inv_desc),
    .inv_done(inv_done), .inv_err(inv_err));

  bit          mv [N];
  logic [39:0] mt [N];
  logic [GW-1:0] mg [N];
  logic [HW-1:0] mh [N];
  int mrr;
  int total = 0, bad = 0;

  function automatic logic [39:0] root_of(int k);
    return {8'hA0 + 8'(k), 32'h5A00_0000 + 32'(k * 7)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_find(logic [39:0] r, logic [GW-1:0] g);
    for (int i = 0; i < N; i++)
      if (mv[i] && mt[i] == r && mg[i] == g) return i;
    return -1;
  endfunction

  task automatic look(logic [39:0] r, logic [GW-1:0] g, string req);
    int idx;
    lk_root = r; lk_gpn = g;
    #1;
    idx = model_find(r, g);
    chk(lk_hit == (idx >= 0), req, "lk_hit", lk_hit, idx >= 0);
    chk(lk_hpn == ((idx >= 0) ? mh[idx] : '0), req, "lk_hpn", lk_hpn, (idx >= 0) ? mh[idx] : 0);
  endtask

  task automatic model_apply();
    bit single, glob, drop, full;
    int fidx;
    single = inv_req && inv_type == 1;
    glob   = inv_req && inv_type == 2;
    drop   = glob || (single && fill_root == inv_desc[51:12]);
    full = 1; fidx = -1;
    for (int i = 0; i < N; i++) if (!mv[i]) begin full = 0; if (fidx < 0) fidx = i; end
    if (full) fidx = mrr;
    for (int i = 0; i < N; i++)
      if (glob || (single && mt[i] == inv_desc[51:12])) mv[i] = 0;
    if (fill_en && !drop) begin
      mv[fidx] = 1; mt[fidx] = fill_root; mg[fidx] = fill_gpn; mh[fidx] = fill_hpn;
      if (full) mrr = (mrr + 1) % N;
    end
  endtask

  task automatic tick(logic [39:0] pr, logic [GW-1:0] pg, string req);
    bit was_req, was_bad;
    was_req = inv_req;
    was_bad = inv_req && inv_type != 1 && inv_type != 2;
    look(lk_root, lk_gpn, "R8");
    model_apply();
    @(posedge clk);
    @(negedge clk);
    fill_en = 0; inv_req = 0;
    chk(inv_done == was_req, "R6", "inv_done", inv_done, was_req);
    chk(inv_err == was_bad, "R7", "inv_err", inv_err, was_bad);
    look(pr, pg, req);
  endtask

  task automatic set_fill(logic [39:0] r, logic [GW-1:0] g, logic [HW-1:0] h);
    fill_en = 1; fill_root = r; fill_gpn = g; fill_hpn = h;
  endtask

  task automatic set_inv(logic [TW-1:0] t, logic [39:0] frame);
    inv_req = 1; inv_type = t;
    inv_desc = {$urandom, $urandom, 12'($urandom), frame, 12'($urandom)};
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 20; g++) look(root_of(k), GW'(g), req);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) mv[i] = 0;
    mrr = 0;
    rst_n = 0; fill_en = 0; inv_req = 0; inv_type = 0; inv_desc = '0;
    fill_root = '0; fill_gpn = '0; fill_hpn = '0; lk_root = '0; lk_gpn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(inv_done == 0, "R1", "inv_done", inv_done, 0);
    chk(inv_err == 0, "R1", "inv_err", inv_err, 0);
    sweep("R1");

    for (int i = 0; i < N; i++) begin
      set_fill(root_of(i % 2), GW'(i), HW'(24'h100 + i));
      tick(root_of(i % 2), GW'(i), "R2");
    end
    sweep("R2");

    set_fill(root_of(2), GW'(9), HW'(24'hBEEF));
    tick(root_of(0), GW'(0), "R3");
    chk(lk_hit == 0, "R3", "victim 0 evicted", lk_hit, 0);
    set_fill(root_of(3), GW'(10), HW'(24'hCAFE));
    tick(root_of(1), GW'(1), "R3");
    chk(lk_hit == 0, "R3", "victim 1 evicted", lk_hit, 0);

    set_inv(1, root_of(1));
    tick(root_of(1), GW'(3), "R4");
    chk(lk_hit == 0, "R4", "frame cleared", lk_hit, 0);
    sweep("R4");
    set_fill(root_of(0), GW'(17), HW'(24'h777));
    tick(root_of(0), GW'(17), "R3");
    sweep("R3");

    set_inv(0, root_of(0)); tick(root_of(0), GW'(2), "R7");
    set_inv(3, root_of(0)); tick(root_of(0), GW'(4), "R7");
    set_inv(8'hFF, root_of(2)); tick(root_of(2), GW'(9), "R7");
    sweep("R7");

    set_fill(root_of(0), GW'(18), HW'(24'h55)); set_inv(1, root_of(0));
    tick(root_of(0), GW'(18), "R8");
    chk(lk_hit == 0, "R8", "colliding fill dropped", lk_hit, 0);
    set_fill(root_of(3), GW'(18), HW'(24'h66)); set_inv(1, root_of(0));
    tick(root_of(3), GW'(18), "R8");
    chk(lk_hit == 1, "R8", "other-frame fill kept", lk_hit, 1);
    set_fill(root_of(2), GW'(19), HW'(24'h99)); set_inv(2, root_of(1));
    tick(root_of(2), GW'(19), "R8");
    sweep("R8");

    set_fill(root_of(1), GW'(5), HW'(24'h12)); tick(root_of(1), GW'(5), "R2");
    set_inv(2, root_of(3)); tick(root_of(1), GW'(5), "R5");
    sweep("R5");

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom % 100);
      lk_root = root_of(int'($urandom % 4)); lk_gpn = GW'($urandom % 8);
      if (op < 65) set_fill(root_of(int'($urandom % 4)), GW'($urandom % 8), HW'($urandom));
      if (op >= 55 && op < 68) set_inv(1, root_of(int'($urandom % 4)));
      else if (op >= 68 && op < 71) set_inv(2, root_of(int'($urandom % 4)));
      else if (op >= 71 && op < 74) set_inv(TW'($urandom), root_of(0));
      tick(root_of(int'($urandom % 4)), GW'($urandom % 8), (op >= 55 && op < 68) ? "R4" : "R3");
    end
    sweep("R4");
    summary();
  end
endmodule